// File: doc/BRIEF.md
# Memory-Mapped OS Tick Timer Channel

A single timer channel for operating-system time keeping, reached through a simple synchronous register bus: a one-cycle write strobe, a one-cycle read strobe, a byte address and 32-bit data. The channel holds a compare register and a counter that software can read but not write. Dedicated trigger registers start and stop the count, and a status bit reports whether the counter is running. One output line pulses for one clock at each event.

Two modes share the counter. In interval mode the count climbs from zero to the compare value and then returns to zero, so one period lasts compare+1 clocks, with an event at each return. In free-running mode the count climbs through the full 32-bit range and wraps. An event fires when the count reaches a nonzero compare value, which gives a one-shot that software ends with a stop. With compare at zero the channel is a plain up-counting time base. The compare value and the mode are sampled at start, so reprogramming a running channel takes effect only at the next start.

Top module: `os_tick_timer`

## Requirements
- R1: After reset the counter, compare, control and status read 0, the channel is stopped and `irq` is low.
- R2: Offset 0x00 holds the 32-bit compare value, read/write. Offset 0x20 is control: only bit 1 is stored (0 = interval mode, 1 = free-running mode), and it reads back as 0x02 or 0x00.
- R3: A write with bit 0 set to the start trigger at offset 0x14 makes the status bit (offset 0x10, bit 0) read 1 from the next cycle, with the counter (offset 0x04) reading 0 in that cycle and rising by one per clock. A start write with bit 0 clear has no effect.
- R4: A write with bit 0 set to the stop trigger at offset 0x18 makes the status bit read 0 from the next cycle, and the counter keeps the value it held when the write arrived.
- R5: In interval mode with compare C the counter runs 0..C and then returns to 0, and `irq` is high for exactly the one cycle in which the counter reads 0 after C, giving a period of C+1 clocks for any C up to 0xFFFFFFFF.
- R6: In free-running mode the counter rises by one per clock and wraps from 0xFFFFFFFF to 0. With nonzero compare C, `irq` is high for one cycle, the cycle in which the counter first reads C. With C = 0 no pulse is produced.
- R7: Compare and control writes while running read back at once but leave the period and the mode in use unchanged until the next start.
- R8: A start write while running restarts the count at 0 and takes up the compare and mode present at that moment.
- R9: A start or stop write that arrives on the clock where an expiry would happen takes precedence: no pulse is produced from that clock.
- R10: Reads of the start and stop triggers and of unmapped offsets return 0. `rdata` is 0 whenever `rd_en` is low.
- R11: `irq` is never high while the channel is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, gates `rdata` |
| addr | input | ADDR_W (6) | Byte offset of the register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, combinational from `addr` |
| irq | output | 1 | One-cycle event pulse |

## Verification
A start or stop command and a period expiry can land on the same clock. Both compete for the counter and the pulse. The bench aims a restart and a stop exactly at the clock where the counter equals the compare value in interval mode. It then judges that no pulse appears, that the count restarts at 0 after the restart or holds the compare value after the stop, and that the later periods line up with the new origin. Random traffic mixes triggers, small compare values and mode writes to hit more such coincidences, and a cycle model in the bench checks every pulse and every read.

// File: rtl/os_tick_timer.sv
module os_tick_timer #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFF_CMP   = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFF_CNT   = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFF_STAT  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFF_START = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] OFF_STOP  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] OFF_CTRL  = ADDR_W'('h20);

  logic [DATA_W-1:0] cmp_q, act_cmp, cnt;
  logic              mode_q, act_free, run;

  wire              hit_start = wr_en && addr == OFF_START && wdata[0];
  wire              hit_stop  = wr_en && addr == OFF_STOP  && wdata[0];
  wire [DATA_W-1:0] cnt_inc   = cnt + 1'b1;
  wire              expire    = !act_free && cnt == act_cmp;
  wire              match     = act_free && act_cmp != '0 && cnt_inc == act_cmp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q    <= '0;
      act_cmp  <= '0;
      cnt      <= '0;
      mode_q   <= 1'b0;
      act_free <= 1'b0;
      run      <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (hit_start) begin
        run      <= 1'b1;
        cnt      <= '0;
        act_cmp  <= cmp_q;
        act_free <= mode_q;
      end else if (hit_stop) begin
        run <= 1'b0;
      end else if (run) begin
        cnt <= expire ? '0 : cnt_inc;
        irq <= expire || match;
      end
      if (wr_en && addr == OFF_CMP)  cmp_q  <= wdata;
      if (wr_en && addr == OFF_CTRL) mode_q <= wdata[1];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFF_CMP:  rdata = cmp_q;
        OFF_CNT:  rdata = cnt;
        OFF_STAT: rdata = {{(DATA_W-1){1'b0}}, run};
        OFF_CTRL: rdata = {{(DATA_W-2){1'b0}}, mode_q, 1'b0};
        default:  rdata = '0;
      endcase
    end
  end
endmodule

module os_tick_timer_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq,
  input logic              run,
  input logic              act_free,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] act_cmp
);
  localparam logic [ADDR_W-1:0] OFF_START = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] OFF_STOP  = ADDR_W'('h18);

  wire go   = wr_en && addr == OFF_START && wdata[0];
  wire halt = wr_en && addr == OFF_STOP  && wdata[0];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!run && !irq && cnt == '0));

  // R3
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (run && cnt == '0));

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!run && $stable(cnt)));

  // R5
  interval_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !act_free && cnt == act_cmp && !go && !halt) |=> (irq && cnt == '0));

  // R6
  free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_free && cnt == '1 && !go && !halt) |=> (cnt == '0));

  // R7
  active_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> ($stable(act_cmp) && $stable(act_free)));

  // R11
  irq_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> run);
endmodule

bind os_tick_timer os_tick_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .run(run), .act_free(act_free), .cnt(cnt), .act_cmp(act_cmp)
);

// File: tb/tb_os_tick_timer.sv
`timescale 1ns/1ps
module tb_os_tick_timer;
  localparam logic [5:0] A_CMP = 6'h00, A_CNT = 6'h04, A_STAT = 6'h10,
                         A_START = 6'h14, A_STOP = 6'h18, A_CTRL = 6'h20, A_HOLE = 6'h08;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  os_tick_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                     .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  int nchk = 0, nerr = 0;
  bit fin = 1'b0;

  logic [31:0] m_cmp, m_acmp, m_cnt;
  logic        m_mode, m_afree, m_run, m_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmp = 0; m_acmp = 0; m_cnt = 0;
      m_mode = 0; m_afree = 0; m_run = 0; m_irq = 0;
    end else begin
      m_irq = 0;
      if (wr_en && addr == A_START && wdata[0]) begin
        m_run = 1; m_cnt = 0; m_acmp = m_cmp; m_afree = m_mode;
      end else if (wr_en && addr == A_STOP && wdata[0]) begin
        m_run = 0;
      end else if (m_run) begin
        if (!m_afree) begin
          if (m_cnt == m_acmp) begin m_cnt = 0; m_irq = 1; end
          else m_cnt = m_cnt + 1;
        end else begin
          m_cnt = m_cnt + 1;
          if (m_acmp != 0 && m_cnt == m_acmp) m_irq = 1;
        end
      end
      if (wr_en && addr == A_CMP)  m_cmp  = wdata;
      if (wr_en && addr == A_CTRL) m_mode = wdata[1];
    end
  end

  function automatic logic [31:0] model_read(input logic r, input logic [5:0] a);
    if (!r) return 0;
    case (a)
      A_CMP:  return m_cmp;
      A_CNT:  return m_cnt;
      A_STAT: return {31'b0, m_run};
      A_CTRL: return {30'b0, m_mode, 1'b0};
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [5:0] a, input logic [31:0] d,
                      output logic [31:0] rd_o, output logic irq_o);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
    rd_o = rdata; irq_o = irq;
    chk("R10 model read", rdata, model_read(r, a));
    chk("R11 model irq", {31'b0, irq}, {31'b0, m_irq});
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic finish_up();
    if (!fin) begin
      fin = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    nerr++;
    $display("FAIL watchdog all requirements got hang exp completion");
    finish_up();
  end

  function automatic logic [5:0] pick(input int k);
    case (k)
      0: return A_CMP;  1: return A_CNT;  2: return A_STAT; 3: return A_START;
      4: return A_STOP; 5: return A_CTRL; default: return A_HOLE;
    endcase
  endfunction

  initial begin
    logic [31:0] rv;
    logic iv;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    step(0,1,A_STAT,0,rv,iv); chk("R1 status", rv, 0); chk("R1 irq", {31'b0,iv}, 0);
    step(0,1,A_CNT,0,rv,iv);  chk("R1 counter", rv, 0);
    step(0,1,A_CMP,0,rv,iv);  chk("R1 compare", rv, 0);
    step(0,1,A_CTRL,0,rv,iv); chk("R1 control", rv, 0);

    // R2 register access
    step(1,0,A_CMP,32'hF,rv,iv);
    step(1,0,A_CTRL,32'hFF,rv,iv);
    step(0,1,A_CTRL,0,rv,iv); chk("R2 control masked", rv, 2);
    step(1,0,A_CTRL,0,rv,iv);
    step(0,1,A_CTRL,0,rv,iv); chk("R2 control cleared", rv, 0);
    step(0,1,A_CMP,0,rv,iv);  chk("R2 compare", rv, 32'hF);

    // R3 start with bit 0 clear is ignored
    step(1,0,A_START,32'hFE,rv,iv);
    step(0,1,A_STAT,0,rv,iv); chk("R3 start bit0 clear ignored", rv, 0);

    // R3 R5 R7 interval mode, period 16, reprogram while running
    step(1,0,A_START,1,rv,iv);
    for (int e = 1; e <= 60; e++) begin
      if (e == 20) step(1,0,A_CMP,5,rv,iv);
      else if (e == 21) step(1,0,A_CTRL,2,rv,iv);
      else if (e == 24) step(1,0,A_CTRL,0,rv,iv);
      else if (e == 22) begin step(0,1,A_CMP,0,rv,iv); chk("R7 compare readback", rv, 5); end
      else if (e == 23) begin step(0,1,A_CTRL,0,rv,iv); chk("R7 control readback", rv, 2); end
      else if (e == 2) begin step(0,1,A_STAT,0,rv,iv); chk("R3 status running", rv, 1); end
      else begin
        step(0,1,A_CNT,0,rv,iv);
        chk(e == 1 ? "R3 count starts at zero" : "R5 R7 interval count", rv, (e-1) % 16);
      end
      chk("R5 R7 interval pulse", {31'b0,iv}, {31'b0, (e > 1 && (e-1) % 16 == 0)});
    end

    // R8 restart with period 6; R9 restart and stop on expiry; R4 stop hold
    step(1,0,A_START,1,rv,iv);
    for (int e = 1; e <= 40; e++) begin
      int ec;
      ec = (e <= 6) ? e - 1 : ((e <= 36) ? (e - 7) % 6 : 5);
      if (e == 6) step(1,0,A_START,1,rv,iv);
      else if (e == 36) step(1,0,A_STOP,1,rv,iv);
      else if (e == 37) begin step(0,1,A_STAT,0,rv,iv); chk("R4 status cleared", rv, 0); end
      else begin
        step(0,1,A_CNT,0,rv,iv);
        chk(e > 37 ? "R4 count held" : (e == 7 ? "R9 restart on expiry" : "R8 restart count"), rv, ec);
      end
      chk(e >= 37 ? "R9 stop on expiry pulse" : "R8 R9 pulse", {31'b0,iv},
          {31'b0, (e > 7 && e <= 36 && (e-7) % 6 == 0)});
    end

    // R6 free-running one-shot
    step(1,0,A_CTRL,2,rv,iv);
    step(1,0,A_CMP,20,rv,iv);
    step(1,0,A_START,1,rv,iv);
    for (int e = 1; e <= 60; e++) begin
      step(0,1,A_CNT,0,rv,iv);
      chk("R6 free count", rv, e - 1);
      chk("R6 compare match pulse", {31'b0,iv}, {31'b0, e == 21});
    end
    step(1,0,A_STOP,1,rv,iv);

    // R6 time base with compare 0
    step(1,0,A_CMP,0,rv,iv);
    step(1,0,A_START,1,rv,iv);
    for (int e = 1; e <= 40; e++) begin
      step(0,1,A_CNT,0,rv,iv);
      chk("R6 time base count", rv, e - 1);
      chk("R6 time base no pulse", {31'b0,iv}, 0);
    end
    step(1,0,A_STOP,1,rv,iv);

    // R5 largest compare value
    step(1,0,A_CTRL,0,rv,iv);
    step(1,0,A_CMP,32'hFFFFFFFF,rv,iv);
    step(1,0,A_START,1,rv,iv);
    for (int e = 1; e <= 100; e++) begin
      step(0,1,A_CNT,0,rv,iv);
      chk("R5 max compare count", rv, e - 1);
      chk("R5 max compare no pulse", {31'b0,iv}, 0);
    end
    step(1,0,A_STOP,1,rv,iv);

    // R10 zero reads
    step(0,1,A_START,0,rv,iv); chk("R10 start reads zero", rv, 0);
    step(0,1,A_STOP,0,rv,iv);  chk("R10 stop reads zero", rv, 0);
    step(0,1,A_HOLE,0,rv,iv);  chk("R10 unmapped reads zero", rv, 0);
    step(0,0,A_CMP,0,rv,iv);   chk("R10 no strobe reads zero", rv, 0);

    // random traffic checked against the model (R11 pulse, R10 reads)
    for (int i = 0; i < 4000; i++) begin
      int p;
      p = $urandom % 100;
      if (p < 60)      step(0,1,pick($urandom % 7),0,rv,iv);
      else if (p < 70) step(1,0,A_CMP,$urandom % 40,rv,iv);
      else if (p < 75) step(1,0,A_CTRL,$urandom,rv,iv);
      else if (p < 81) step(1,0,A_START,$urandom % 4,rv,iv);
      else if (p < 85) step(1,0,A_STOP,$urandom % 4,rv,iv);
      else             step(0,0,A_CMP,0,rv,iv);
    end

    finish_up();
  end
endmodule